// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the parallel programming port of a small on-chip program flash: a byte array addressed by a 12-bit bus (4096 bytes by default) plus three lock bits. An external programmer selects an operation on a 3-bit mode bus, places an address and a data byte on the inputs, and strobes an active-low program pulse. The block then times the byte write itself, holds a ready output low while the write runs, and lets the programmer poll the written location. During that time bit 7 of the read data is the complement of the byte being written.

A chip erase is requested by holding the program pulse low for a set number of clock cycles in erase mode. The controller then sweeps the whole array to FFH, one byte per cycle, and clears the lock bits at the end. Programming can only clear bits, so ones are restored only by an erase. A signature mode returns fixed identification bytes. Two lock bits block verify reads. One lock bit also makes the block latch the external-access pin level during device reset and report whether the live pin still agrees with it.

A power-on reset runs the same sweep, so the array starts fully erased. Write time and erase hold time are parameters, so a simulation can use short counts.

Top module: `flashprog_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low, then high), `ready` stays low for exactly 2^ADDR_W cycles while the array is swept. Afterwards every byte reads FFH in verify mode (`mode` = 3'b000).
- R2: In program mode (`mode` = 3'b001) with `vpp_ok` high, a rising edge of `prog_n` starts one byte write. `ready` goes low on the next clock and stays low for exactly WRITE_CYCLES cycles.
- R3: While a byte write is running, a verify read of its address returns bit 7 inverted and bits 6:0 unchanged from the byte being written. Once `ready` is high, the stored value is returned.
- R4: A byte write stores the bitwise AND of the old content and the new byte, so it only ever clears bits.
- R5: In erase mode (`mode` = 3'b010) with `vpp_ok` high, holding `prog_n` low for ERASE_HOLD sampled cycles starts an erase. `ready` is low for 2^ADDR_W cycles, after which every byte is FFH and all lock bits are clear. A pulse one cycle shorter does nothing.
- R6: In signature mode (`mode` = 3'b011), address 030H reads 1EH and 031H reads 51H. Address 032H reads FFH, or 05H when LOW_VCC_PART is set. Any other address reads 00H.
- R7: With `vpp_ok` low, program, erase and lock requests are ignored: `ready` stays high and the array is unchanged.
- R8: While `ready` is low, new program pulses are ignored. The running write keeps its address, data and length.
- R9: Once lock bit 1 (`mode` 3'b100) or lock bit 2 (`mode` 3'b101) is programmed, verify reads return 00H until the next erase. Lock bit 3 (`mode` 3'b110) is stored and cleared by erase.
- R10: With lock bit 1 set, `ea_pin` is latched on every clock while `rst_n` is low, and `ea_ok` is high only when the live `ea_pin` equals the latched level. With lock bit 1 clear, `ea_ok` is high.
- R11: In program, erase, lock and idle modes (`mode` = 3'b111), `data_out` is 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Device reset, active low; samples `ea_pin` when lock bit 1 is set |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Verify, poll or signature read data |
| mode | input | 3 | Operation select |
| prog_n | input | 1 | Program pulse, active low |
| vpp_ok | input | 1 | Programming voltage present |
| ea_pin | input | 1 | External-access pin level |
| ready | output | 1 | High when idle, low while a write or erase runs |
| ea_ok | output | 1 | Latched external-access level agrees with the pin |

## Verification
A corrupted write timer shows up as a `ready` low window that is too short or too long, which is visible on the first write. A lost target address or data byte appears at the poll read, on the cycle after the write starts, and again in the stored value once `ready` rises. A stuck lock bit turns every verify read into 00H, and a lock bit that erase fails to clear is seen in the first read after the sweep. Both are observable within a single read.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MODE_VERIFY  = 3'b000,
        MODE_PROGRAM = 3'b001,
        MODE_ERASE   = 3'b010,
        MODE_SIGN    = 3'b011,
        MODE_LOCK1   = 3'b100,
        MODE_LOCK2   = 3'b101,
        MODE_LOCK3   = 3'b110,
        MODE_NONE    = 3'b111
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE,
        ST_LOCK,
        ST_SWEEP
    } ctl_state_e;

    localparam logic [BYTE_W-1:0] SIG_MAKER    = 8'h1E;
    localparam logic [BYTE_W-1:0] SIG_PART     = 8'h51;
    localparam logic [BYTE_W-1:0] SIG_HV       = 8'hFF;
    localparam logic [BYTE_W-1:0] SIG_LV       = 8'h05;
    localparam logic [BYTE_W-1:0] READ_BLOCKED = 8'h00;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flashprog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells_q [DEPTH];
    logic [BYTE_W-1:0] cell_d;

    // A program write can only pull bits low; the fill path restores ones.
    always_comb begin
        if (wr_fill) cell_d = {BYTE_W{1'b1}};
        else         cell_d = cells_q[wr_addr] & wr_data;
    end

    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_addr] <= cell_d;
    end

    assign rd_data = cells_q[rd_addr];

endmodule

// File: rtl/prog_pulse_decoder.sv
module prog_pulse_decoder #(
    parameter int HOLD_CYCLES = 10000
) (
    input  logic clk,
    input  logic por_n,
    input  logic prog_n,
    output logic pulse_rise,
    output logic hold_hit
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          level;
        logic [HW-1:0] low_cnt;
    } pulse_t;

    pulse_t pd_d, pd_q;

    always_comb begin
        pd_d       = pd_q;
        pd_d.level = prog_n;
        if (prog_n)                              pd_d.low_cnt = '0;
        else if (pd_q.low_cnt != HW'(HOLD_CYCLES)) pd_d.low_cnt = pd_q.low_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pd_q <= '{level: 1'b1, low_cnt: '0};
        else        pd_q <= pd_d;
    end

    assign pulse_rise = prog_n & ~pd_q.level;
    assign hold_hit   = ~prog_n && (pd_q.low_cnt == HW'(HOLD_CYCLES - 1));

    AST_HOLD_HIT_ONCE: assert property (@(posedge clk) disable iff (!por_n)
        hold_hit |=> !hold_hit); // R5

endmodule

// File: rtl/flash_sig_rom.sv
module flash_sig_rom
    import flashprog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter bit LOW_VCC_PART = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] sig_byte
);
    logic [BYTE_W-1:0] volt_byte;

    generate
        if (LOW_VCC_PART) begin : g_low_vcc
            assign volt_byte = SIG_LV;
        end else begin : g_high_vpp
            assign volt_byte = SIG_HV;
        end
    endgenerate

    always_comb begin
        if (addr == ADDR_W'('h30))      sig_byte = SIG_MAKER;
        else if (addr == ADDR_W'('h31)) sig_byte = SIG_PART;
        else if (addr == ADDR_W'('h32)) sig_byte = volt_byte;
        else                            sig_byte = READ_BLOCKED;
    end

endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
    import flashprog_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 1500,
    parameter int ERASE_HOLD   = 10000,
    parameter bit LOW_VCC_PART = 1'b0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    input  logic [2:0]        mode,
    input  logic              prog_n,
    input  logic              vpp_ok,
    input  logic              ea_pin,
    output logic              ready,
    output logic              ea_ok
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  timer;
        logic [ADDR_W-1:0] tgt_addr;
        logic [BYTE_W-1:0] tgt_data;
        logic [1:0]        lock_idx;
        logic [ADDR_W-1:0] sweep;
        logic [2:0]        locks;
        logic              ea_latch;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_SWEEP, timer: '0, tgt_addr: '0, tgt_data: '0,
        lock_idx: '0, sweep: '0, locks: '0, ea_latch: 1'b0
    };

    ctl_t cq_d, cq_q;

    op_mode_e          mode_e;
    logic              pulse_rise, hold_hit;
    logic              arr_we, arr_fill;
    logic [ADDR_W-1:0] arr_waddr;
    logic [BYTE_W-1:0] arr_rdata, sig_byte;
    logic              lock_req;

    assign mode_e   = op_mode_e'(mode);
    assign lock_req = (mode_e == MODE_LOCK1) || (mode_e == MODE_LOCK2) ||
                      (mode_e == MODE_LOCK3);

    prog_pulse_decoder #(.HOLD_CYCLES(ERASE_HOLD)) u_pulse (
        .clk       (clk),
        .por_n     (por_n),
        .prog_n    (prog_n),
        .pulse_rise(pulse_rise),
        .hold_hit  (hold_hit)
    );

    flash_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .wr_en  (arr_we),
        .wr_fill(arr_fill),
        .wr_addr(arr_waddr),
        .wr_data(cq_q.tgt_data),
        .rd_addr(addr),
        .rd_data(arr_rdata)
    );

    flash_sig_rom #(.ADDR_W(ADDR_W), .LOW_VCC_PART(LOW_VCC_PART)) u_sig (
        .addr    (addr),
        .sig_byte(sig_byte)
    );

    // Next-state logic: operation sequencing, lock bits and access latch
    always_comb begin
        cq_d      = cq_q;
        arr_we    = 1'b0;
        arr_fill  = 1'b0;
        arr_waddr = cq_q.tgt_addr;

        unique case (cq_q.st)
            ST_IDLE: begin
                if (vpp_ok) begin
                    if (pulse_rise && mode_e == MODE_PROGRAM) begin
                        cq_d.st       = ST_BYTE;
                        cq_d.timer    = CNT_W'(WRITE_CYCLES - 1);
                        cq_d.tgt_addr = addr;
                        cq_d.tgt_data = data_in;
                    end else if (pulse_rise && lock_req) begin
                        cq_d.st       = ST_LOCK;
                        cq_d.timer    = CNT_W'(WRITE_CYCLES - 1);
                        cq_d.lock_idx = mode[1:0];
                    end else if (hold_hit && mode_e == MODE_ERASE) begin
                        cq_d.st    = ST_SWEEP;
                        cq_d.sweep = '0;
                    end
                end
            end
            ST_BYTE: begin
                if (cq_q.timer == '0) begin
                    arr_we  = 1'b1;
                    cq_d.st = ST_IDLE;
                end else begin
                    cq_d.timer = cq_q.timer - 1'b1;
                end
            end
            ST_LOCK: begin
                if (cq_q.timer == '0) begin
                    case (cq_q.lock_idx)
                        2'd0:    cq_d.locks[0] = 1'b1;
                        2'd1:    cq_d.locks[1] = 1'b1;
                        default: cq_d.locks[2] = 1'b1;
                    endcase
                    cq_d.st = ST_IDLE;
                end else begin
                    cq_d.timer = cq_q.timer - 1'b1;
                end
            end
            ST_SWEEP: begin
                arr_we     = 1'b1;
                arr_fill   = 1'b1;
                arr_waddr  = cq_q.sweep;
                cq_d.sweep = cq_q.sweep + 1'b1;
                if (cq_q.sweep == ADDR_W'(DEPTH - 1)) begin
                    cq_d.locks = '0;
                    cq_d.st    = ST_IDLE;
                end
            end
            default: cq_d.st = ST_IDLE;
        endcase

        if (!rst_n && cq_q.locks[0]) cq_d.ea_latch = ea_pin;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cq_q <= CTL_RST;
        else        cq_q <= cq_d;
    end

    // Read path: poll, protected verify, signature
    always_comb begin
        data_out = READ_BLOCKED;
        case (mode_e)
            MODE_VERIFY: begin
                if (cq_q.st == ST_BYTE && addr == cq_q.tgt_addr)
                    data_out = {~cq_q.tgt_data[7], cq_q.tgt_data[6:0]};
                else if (cq_q.locks[0] || cq_q.locks[1])
                    data_out = READ_BLOCKED;
                else
                    data_out = arr_rdata;
            end
            MODE_SIGN: data_out = sig_byte;
            default:   data_out = READ_BLOCKED;
        endcase
    end

    assign ready = (cq_q.st == ST_IDLE);
    assign ea_ok = !cq_q.locks[0] || (cq_q.ea_latch == ea_pin);

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!por_n)
        (ready && vpp_ok && pulse_rise && mode == MODE_PROGRAM) |=> !ready); // R2

    AST_NO_VPP_STAYS_READY: assert property (@(posedge clk) disable iff (!por_n)
        (ready && !vpp_ok) |=> ready); // R7

    AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!por_n)
        (cq_q.st == ST_BYTE && cq_q.timer != '0) |=>
        ($stable(cq_q.tgt_addr) && $stable(cq_q.tgt_data) && !ready)); // R8

    AST_ERASE_CLEARS_LOCKS: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(ready) && $past(cq_q.st) == ST_SWEEP) |-> (cq_q.locks == 3'b000)); // R5

    AST_SIG_MAKER_BYTE: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MODE_SIGN && addr == ADDR_W'('h30)) |-> (data_out == SIG_MAKER)); // R6

    AST_EA_LATCH_HELD: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |=> $stable(cq_q.ea_latch)); // R10

endmodule

// File: tb/test_flashprog_ctrl.sv
module test_flashprog_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int DEPTH      = 1 << AW;
    localparam int WCYC       = 20;
    localparam int HOLD       = 8;

    localparam logic [2:0] M_VERIFY = 3'b000, M_PROG = 3'b001, M_ERASE = 3'b010,
                           M_SIGN = 3'b011, M_LOCK1 = 3'b100, M_LOCK2 = 3'b101,
                           M_NONE = 3'b111;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [7:0]    e;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{a: 12'h001, d: 8'hA5, e: 8'hA5},
        '{a: 12'h002, d: 8'h3C, e: 8'h3C},
        '{a: 12'h001, d: 8'hF0, e: 8'hA0},
        '{a: 12'hFFF, d: 8'h7E, e: 8'h7E},
        '{a: 12'h000, d: 8'h00, e: 8'h00},
        '{a: 12'h800, d: 8'h81, e: 8'h81}
    };

    logic          clk = 1'b0;
    logic          por_n, rst_n, prog_n, vpp_ok, ea_pin;
    logic [AW-1:0] addr;
    logic [7:0]    data_in, data_out;
    logic [2:0]    mode;
    logic          ready, ea_ok;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flashprog_ctrl #(
        .ADDR_W(AW), .WRITE_CYCLES(WCYC), .ERASE_HOLD(HOLD), .LOW_VCC_PART(1'b0)
    ) i_flashprog_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .mode(mode), .prog_n(prog_n), .vpp_ok(vpp_ok),
        .ea_pin(ea_pin), .ready(ready), .ea_ok(ea_ok)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (ready !== 1'b1 && n < 20000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); mode = m; addr = a; data_in = d; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic read_at(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); mode = m; addr = a; #1;
        v = data_out;
    endtask

    task automatic hold_erase(input int cycles);
        @(negedge clk); mode = M_ERASE; prog_n = 1'b0;
        repeat (cycles) @(negedge clk);
        prog_n = 1'b1; #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v;
        por_n = 1'b0; rst_n = 1'b0; prog_n = 1'b1; vpp_ok = 1'b1; ea_pin = 1'b0;
        mode = M_NONE; addr = '0; data_in = '0;
        repeat (3) @(negedge clk);
        #1 check("R1 ready low in power-on reset", ready, 0);
        por_n = 1'b1; rst_n = 1'b1; #1;
        wait_ready(n);
        check("R1 power-on sweep length", n, DEPTH);
        read_at(M_VERIFY, 12'h000, v); check("R1 erased byte 000", v, 8'hFF);
        read_at(M_VERIFY, 12'h123, v); check("R1 erased byte 123", v, 8'hFF);
        read_at(M_VERIFY, 12'hFFF, v); check("R1 erased byte FFF", v, 8'hFF);

        // Table walk: program, poll, time, verify (R2, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            pulse(M_PROG, VEC[i].a, VEC[i].d);
            mode = M_VERIFY; #1;
            check("R3 poll read inverts bit 7", data_out, {~VEC[i].d[7], VEC[i].d[6:0]});
            wait_ready(n);
            check("R2 write busy length", n, WCYC);
            check("R4 stored value after write", data_out, VEC[i].e);
        end

        // R6 signature
        read_at(M_SIGN, 12'h030, v); check("R6 maker byte", v, 8'h1E);
        read_at(M_SIGN, 12'h031, v); check("R6 part byte", v, 8'h51);
        read_at(M_SIGN, 12'h032, v); check("R6 voltage byte", v, 8'hFF);
        read_at(M_SIGN, 12'h033, v); check("R6 other address", v, 8'h00);

        // R11 non-read modes
        read_at(M_NONE, 12'h001, v); check("R11 idle mode output", v, 8'h00);
        read_at(M_PROG, 12'h001, v); check("R11 program mode output", v, 8'h00);

        // R7 no programming voltage
        vpp_ok = 1'b0;
        pulse(M_PROG, 12'h010, 8'h00);
        check("R7 ready stays high without vpp", ready, 1);
        read_at(M_VERIFY, 12'h010, v); check("R7 byte unchanged without vpp", v, 8'hFF);
        hold_erase(HOLD);
        check("R7 erase ignored without vpp", ready, 1);
        read_at(M_VERIFY, 12'h001, v); check("R7 byte kept without vpp", v, 8'hA0);
        vpp_ok = 1'b1;

        // R8 pulse while busy ignored
        pulse(M_PROG, 12'h020, 8'h55);
        pulse(M_PROG, 12'h021, 8'h00);
        wait_ready(n);
        check("R8 busy length unchanged", n + 3, WCYC);
        read_at(M_VERIFY, 12'h020, v); check("R8 first write stored", v, 8'h55);
        read_at(M_VERIFY, 12'h021, v); check("R8 second write ignored", v, 8'hFF);

        // R5 short erase pulse does nothing
        hold_erase(HOLD - 1);
        check("R5 short pulse leaves ready high", ready, 1);
        read_at(M_VERIFY, 12'h001, v); check("R5 short pulse keeps data", v, 8'hA0);

        // R9 lock bit 2 blocks verify
        ea_pin = 1'b1;
        #1 check("R10 ea_ok high with lock 1 clear", ea_ok, 1);
        pulse(M_LOCK2, 12'h000, 8'h00);
        wait_ready(n);
        check("R9 lock write length", n, WCYC);
        read_at(M_VERIFY, 12'h001, v); check("R9 read blocked by lock 2", v, 8'h00);
        read_at(M_SIGN, 12'h031, v); check("R9 signature still readable", v, 8'h51);

        // R5 full erase
        hold_erase(HOLD);
        wait_ready(n);
        check("R5 erase sweep length", n, DEPTH);
        read_at(M_VERIFY, 12'h001, v); check("R5 erased and unlocked 001", v, 8'hFF);
        read_at(M_VERIFY, 12'h020, v); check("R5 erased and unlocked 020", v, 8'hFF);

        // R10 access latch with lock bit 1
        pulse(M_LOCK1, 12'h000, 8'h00);
        wait_ready(n);
        check("R10 mismatch after lock 1 set", ea_ok, 0);
        read_at(M_VERIFY, 12'h002, v); check("R9 read blocked by lock 1", v, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; #1;
        check("R10 latched level matches pin", ea_ok, 1);
        ea_pin = 1'b0; #1;
        check("R10 pin change after reset flagged", ea_ok, 0);
        ea_pin = 1'b1; #1;
        check("R10 pin restored", ea_ok, 1);

        hold_erase(HOLD);
        wait_ready(n);
        ea_pin = 1'b0; #1;
        check("R5 erase clears lock 1", ea_ok, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule